// File: doc/BRIEF.md
# Hardware Cursor Scanline Overlay

This block draws one scanline of a 64-pixel, two-colour hardware cursor over a display pixel stream. When a cursor line begins, it reads the line's pattern from memory as 16-bit words through a simple fetch port. During the same few cycles it resolves the cursor's foreground and background colours into 32-bit RGB for the current pixel depth. For 8-bit depth this uses an external palette reached through a lookup port.

Once the line is prepared, each incoming pixel whose screen column falls inside the cursor is either replaced by a cursor colour or passed through unchanged, as the pattern's mask and data bits decide. An alternate mode, meant for a later device revision, takes the colour inputs as they are for every depth and inverts the sense of the mask. Frame timing, cursor position and colours are inputs; the block generates no timing of its own.

The fetch port and the palette port both return data one clock after the request. The pixel path has one register stage.

Top module: `hwcur_overlay`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `out_ovr` and `fetch_req` are low until stimulus arrives.
- R2: After `line_start`, exactly 8 fetch requests follow on consecutive cycles at byte addresses L, L+2, …, L+14. L equals `base_addr` when `frame_start` accompanies `line_start`. Otherwise L equals the previous line's address plus 16.
- R3: Cursor column c (0..63) sits at screen column `cur_x + c`. It uses group g = c/16 and bit 15-(c mod 16), so the most significant bit comes first. The mask word of group g is at L+4g and the data word at L+4g+2. With the mask bit set, the output is the foreground colour when the data bit is 1 and the background colour when it is 0. With the mask bit clear, the input pixel passes through.
- R4: With depth code 0 (8 bpp), the colours come from the palette. The block looks up index `fg_col[7:0]` and then `bg_col[7:0]` on `pal_idx`, and uses the returned words.
- R5: With depth code 1 (15 bpp), the colour's low 16 bits are read as R[14:10], G[9:5], B[4:0]. Each 5-bit channel becomes 8 bits by appending its top 3 bits, and the top byte is zero.
- R6: With depth code 2 (16 bpp), the colour is read as R[15:11], G[10:5], B[4:0]. 5-bit channels append their top 3 bits, the 6-bit channel appends its top 2 bits, and the top byte is zero.
- R7: With depth code 3 (24 bpp), 4 (32 bpp) or any other code, the 32-bit colour inputs are used unchanged.
- R8: With `alt_mode` high at `line_start`, the colour inputs are used unchanged at every depth and each mask bit is inverted before it is tested.
- R9: Only pixels presented on the stream (non-negative columns) can be overridden. With `cur_x` negative, cursor columns that would land left of column 0 are never shown, and screen column x shows cursor column x - `cur_x`.
- R10: Colours, depth and `alt_mode` are captured at `line_start`. Changing them during the line does not change the line's output.
- R11: `out_valid` and `out_rgb` follow `pix_valid` and `pix_rgb` one cycle later. No pixel is overridden while a line is being prepared or while `cur_on` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Reload the line address from `base_addr` |
| line_start | input | 1 | Begin preparing a cursor line |
| base_addr | input | ADDR_W | Byte address of the cursor's first line |
| depth | input | 3 | Pixel depth code (0:8, 1:15, 2:16, 3:24, 4:32 bpp) |
| alt_mode | input | 1 | Alternate revision mode |
| fg_col | input | PIX_W | Foreground colour register |
| bg_col | input | PIX_W | Background colour register |
| cur_on | input | 1 | Cursor visible on this line |
| cur_x | input | X_W+1 | Signed screen column of cursor column 0 |
| fetch_req | output | 1 | Pattern word read request |
| fetch_addr | output | ADDR_W | Byte address of the requested word |
| fetch_rdata | input | GRP_W | Word returned one cycle after the request |
| pal_idx | output | 8 | Palette index |
| pal_rgb | input | PIX_W | Palette entry returned one cycle later |
| pix_valid | input | 1 | Incoming pixel valid |
| pix_x | input | X_W | Screen column of the incoming pixel |
| pix_rgb | input | PIX_W | Incoming pixel colour |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | PIX_W | Output pixel colour |
| out_ovr | output | 1 | Output pixel was replaced by the cursor |

## Verification
Every depth code is scanned across a full cursor line. The foreground, background and palette values are chosen so that palette lookup, 5-5-5 expansion, 5-6-5 expansion and raw use each produce different words. A wrong conversion or a swapped colour therefore shows at the first pixel it affects. Pattern words mix set and clear bits, so a bit-order or group-order error misplaces overrides. A second line without a frame reload tests the 16-byte address step. The alternate mode is run at 8 and 15 bpp, where it must differ from normal mode in both colour and mask sense. A negative cursor position, changes to the inputs mid-line, pixels sent during preparation, and a lowered `cur_on` cover clipping, colour latching and the pass-through cases.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;

   typedef enum logic [2:0] {
      DEP_8  = 3'd0,
      DEP_15 = 3'd1,
      DEP_16 = 3'd2,
      DEP_24 = 3'd3,
      DEP_32 = 3'd4
   } depth_e;

   // 5-5-5 word to 8-8-8, low bits filled from each channel's top bits
   function automatic logic [31:0] rgb555_to_32(input logic [15:0] c);
      logic [4:0] r, g, b;
      r = c[14:10];
      g = c[9:5];
      b = c[4:0];
      return {8'h00, r, r[4:2], g, g[4:2], b, b[4:2]};
   endfunction

   // 5-6-5 word to 8-8-8
   function automatic logic [31:0] rgb565_to_32(input logic [15:0] c);
      logic [4:0] r, b;
      logic [5:0] g;
      r = c[15:11];
      g = c[10:5];
      b = c[4:0];
      return {8'h00, r, r[4:2], g, g[5:4], b, b[4:2]};
   endfunction

endpackage

// File: rtl/hwcur_fetch_seq.sv
// Per-line sequencer: pattern word reads and palette lookups.
module hwcur_fetch_seq #(
   parameter int ADDR_W = 24,
   parameter int GRP_W  = 16,
   parameter int NGRP   = 4,
   parameter int PIX_W  = 32,
   parameter int PAL_W  = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        frame_start,
   input  logic                        line_start,
   input  logic [ADDR_W-1:0]           base_addr,
   input  logic [PAL_W-1:0]            fg_idx,
   input  logic [PAL_W-1:0]            bg_idx,
   output logic                        fetch_req,
   output logic [ADDR_W-1:0]           fetch_addr,
   input  logic [GRP_W-1:0]            fetch_rdata,
   output logic [PAL_W-1:0]            pal_idx,
   input  logic [PIX_W-1:0]            pal_rgb,
   output logic [NGRP-1:0][GRP_W-1:0]  mask_w,
   output logic [NGRP-1:0][GRP_W-1:0]  data_w,
   output logic [PIX_W-1:0]            pal_fg,
   output logic [PIX_W-1:0]            pal_bg,
   output logic                        done,
   output logic                        ready
);
   localparam int NWORD      = 2 * NGRP;
   localparam int CNT_W      = $clog2(NWORD + 1);
   localparam int WORD_BYTES = GRP_W / 8;
   localparam int LINE_BYTES = NWORD * WORD_BYTES;

   logic              busy;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] next_addr;
   logic [ADDR_W-1:0] start_addr;
   logic [GRP_W-1:0]  word_q [NWORD];

   assign start_addr = frame_start ? base_addr : next_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cnt       <= '0;
         ready     <= 1'b0;
         cur_addr  <= '0;
         next_addr <= '0;
      end else if (line_start) begin
         busy      <= 1'b1;
         cnt       <= '0;
         ready     <= 1'b0;
         cur_addr  <= start_addr;
         next_addr <= start_addr + ADDR_W'(LINE_BYTES);
      end else begin
         if (frame_start)
            next_addr <= base_addr;
         if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(NWORD)) begin
               busy  <= 1'b0;
               ready <= 1'b1;
            end
         end
      end
   end

   assign done       = busy && (cnt == CNT_W'(NWORD));
   assign fetch_req  = busy && (cnt < CNT_W'(NWORD));
   assign fetch_addr = cur_addr + ADDR_W'(cnt) * ADDR_W'(WORD_BYTES);
   assign pal_idx    = (cnt == '0) ? fg_idx : bg_idx;

   // word k is returned while cnt == k+1
   for (genvar w = 0; w < NWORD; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q[w] <= '0;
         else if (busy && cnt == CNT_W'(w + 1))
            word_q[w] <= fetch_rdata;
      end
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign mask_w[g] = word_q[2*g];
      assign data_w[g] = word_q[2*g+1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pal_fg <= '0;
         pal_bg <= '0;
      end else if (busy) begin
         if (cnt == CNT_W'(1)) pal_fg <= pal_rgb;
         if (cnt == CNT_W'(2)) pal_bg <= pal_rgb;
      end
   end

endmodule

// File: rtl/hwcur_colour_conv.sv
// Depth-dependent conversion of one cursor colour.
module hwcur_colour_conv
   import hwcur_pkg::*;
#(
   parameter int PIX_W = 32
) (
   input  logic [2:0]       depth,
   input  logic             alt_mode,
   input  logic [PIX_W-1:0] raw,
   input  logic [PIX_W-1:0] pal,
   output logic [PIX_W-1:0] rgb
);
   if (PIX_W != 32) begin : g_bad_pix
      $error("hwcur_colour_conv: PIX_W must be 32");
   end

   always_comb begin
      rgb = raw;
      if (!alt_mode) begin
         case (depth_e'(depth))
            DEP_8:   rgb = pal;
            DEP_15:  rgb = rgb555_to_32(raw[15:0]);
            DEP_16:  rgb = rgb565_to_32(raw[15:0]);
            default: rgb = raw;
         endcase
      end
   end

endmodule

// File: rtl/hwcur_pix_mix.sv
// Column decode, mask test and registered output stage.
module hwcur_pix_mix #(
   parameter int CUR_W = 64,
   parameter int GRP_W = 16,
   parameter int X_W   = 12,
   parameter int PIX_W = 32
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                ready,
   input  logic                                cur_on,
   input  logic                                alt_mode,
   input  logic [X_W:0]                        cur_x,
   input  logic [CUR_W/GRP_W-1:0][GRP_W-1:0]   mask_w,
   input  logic [CUR_W/GRP_W-1:0][GRP_W-1:0]   data_w,
   input  logic [PIX_W-1:0]                    fg,
   input  logic [PIX_W-1:0]                    bg,
   input  logic                                pix_valid,
   input  logic [X_W-1:0]                      pix_x,
   input  logic [PIX_W-1:0]                    pix_rgb,
   output logic                                out_valid,
   output logic [PIX_W-1:0]                    out_rgb,
   output logic                                out_ovr
);
   localparam int LG  = $clog2(GRP_W);
   localparam int LC  = $clog2(CUR_W);
   localparam int C_W = X_W + 2;
   localparam logic [C_W-1:0] CUR_W_L = C_W'(CUR_W);
   localparam logic [LG-1:0]  TOP_BIT = LG'(GRP_W - 1);

   logic [C_W-1:0] col;
   logic           in_win;
   logic [LC-LG-1:0] g_idx;
   logic [LG-1:0]  b_sel;
   logic           m_bit, d_bit, hit;

   assign col    = {2'b00, pix_x} - {cur_x[X_W], cur_x};
   assign in_win = !col[C_W-1] && (col < CUR_W_L);
   assign g_idx  = col[LC-1:LG];
   assign b_sel  = TOP_BIT - col[LG-1:0];
   assign m_bit  = mask_w[g_idx][b_sel] ^ alt_mode;
   assign d_bit  = data_w[g_idx][b_sel];
   assign hit    = ready && cur_on && in_win && m_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_ovr   <= 1'b0;
         out_rgb   <= '0;
      end else begin
         out_valid <= pix_valid;
         out_ovr   <= pix_valid && hit;
         out_rgb   <= hit ? (d_bit ? fg : bg) : pix_rgb;
      end
   end

endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay #(
   parameter int CUR_W  = 64,
   parameter int GRP_W  = 16,
   parameter int ADDR_W = 24,
   parameter int X_W    = 12,
   parameter int PIX_W  = 32,
   parameter int PAL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [2:0]        depth,
   input  logic              alt_mode,
   input  logic [PIX_W-1:0]  fg_col,
   input  logic [PIX_W-1:0]  bg_col,
   input  logic              cur_on,
   input  logic [X_W:0]      cur_x,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic [GRP_W-1:0]  fetch_rdata,
   output logic [PAL_W-1:0]  pal_idx,
   input  logic [PIX_W-1:0]  pal_rgb,
   input  logic              pix_valid,
   input  logic [X_W-1:0]    pix_x,
   input  logic [PIX_W-1:0]  pix_rgb,
   output logic              out_valid,
   output logic [PIX_W-1:0]  out_rgb,
   output logic              out_ovr
);
   localparam int NGRP = CUR_W / GRP_W;

   if (CUR_W % GRP_W != 0 || (1 << $clog2(CUR_W)) != CUR_W ||
       (1 << $clog2(GRP_W)) != GRP_W) begin : g_bad_geom
      $error("hwcur_overlay: CUR_W and GRP_W must be powers of two, GRP_W dividing CUR_W");
   end
   if (NGRP < 2 || GRP_W % 8 != 0) begin : g_bad_grp
      $error("hwcur_overlay: need at least two groups of whole bytes");
   end
   if (X_W < $clog2(CUR_W) || PAL_W > PIX_W) begin : g_bad_w
      $error("hwcur_overlay: X_W or PAL_W out of range");
   end

   // per-line captured controls
   logic [PIX_W-1:0] lat_fg, lat_bg;
   logic [2:0]       lat_depth;
   logic             lat_alt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_fg    <= '0;
         lat_bg    <= '0;
         lat_depth <= '0;
         lat_alt   <= 1'b0;
      end else if (line_start) begin
         lat_fg    <= fg_col;
         lat_bg    <= bg_col;
         lat_depth <= depth;
         lat_alt   <= alt_mode;
      end
   end

   logic [NGRP-1:0][GRP_W-1:0] mask_w, data_w;
   logic [PIX_W-1:0] pal_fg, pal_bg, conv_fg, conv_bg, fg_q, bg_q;
   logic             done, ready;

   hwcur_fetch_seq #(
      .ADDR_W(ADDR_W), .GRP_W(GRP_W), .NGRP(NGRP), .PIX_W(PIX_W), .PAL_W(PAL_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .frame_start(frame_start), .line_start(line_start), .base_addr(base_addr),
      .fg_idx(lat_fg[PAL_W-1:0]), .bg_idx(lat_bg[PAL_W-1:0]),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_rdata(fetch_rdata),
      .pal_idx(pal_idx), .pal_rgb(pal_rgb),
      .mask_w(mask_w), .data_w(data_w),
      .pal_fg(pal_fg), .pal_bg(pal_bg),
      .done(done), .ready(ready)
   );

   hwcur_colour_conv #(.PIX_W(PIX_W)) u_conv_fg (
      .depth(lat_depth), .alt_mode(lat_alt), .raw(lat_fg), .pal(pal_fg), .rgb(conv_fg)
   );

   hwcur_colour_conv #(.PIX_W(PIX_W)) u_conv_bg (
      .depth(lat_depth), .alt_mode(lat_alt), .raw(lat_bg), .pal(pal_bg), .rgb(conv_bg)
   );

   // colours frozen once per line when the sequence completes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fg_q <= '0;
         bg_q <= '0;
      end else if (done) begin
         fg_q <= conv_fg;
         bg_q <= conv_bg;
      end
   end

   hwcur_pix_mix #(
      .CUR_W(CUR_W), .GRP_W(GRP_W), .X_W(X_W), .PIX_W(PIX_W)
   ) u_mix (
      .clk(clk), .rst_n(rst_n),
      .ready(ready), .cur_on(cur_on), .alt_mode(lat_alt), .cur_x(cur_x),
      .mask_w(mask_w), .data_w(data_w), .fg(fg_q), .bg(bg_q),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_rgb(pix_rgb),
      .out_valid(out_valid), .out_rgb(out_rgb), .out_ovr(out_ovr)
   );

endmodule

// File: rtl/hwcur_overlay_chk.sv
module hwcur_overlay_chk #(
   parameter int CUR_W  = 64,
   parameter int GRP_W  = 16,
   parameter int ADDR_W = 24,
   parameter int X_W    = 12,
   parameter int PIX_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_start,
   input logic              fetch_req,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              cur_on,
   input logic [X_W:0]      cur_x,
   input logic              pix_valid,
   input logic [X_W-1:0]    pix_x,
   input logic [PIX_W-1:0]  pix_rgb,
   input logic              out_valid,
   input logic [PIX_W-1:0]  out_rgb,
   input logic              out_ovr
);
   localparam int NWORD = 2 * CUR_W / GRP_W;
   localparam int RC_W  = $clog2(NWORD + 2);
   localparam int C_W   = X_W + 2;

   logic [RC_W-1:0] req_cnt;
   logic            win_q;
   logic signed [C_W-1:0] col_s;

   assign col_s = $signed({2'b00, pix_x}) - $signed({cur_x[X_W], cur_x});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_cnt <= '0;
         win_q   <= 1'b0;
      end else begin
         if (line_start)
            req_cnt <= '0;
         else if (fetch_req && req_cnt <= RC_W'(NWORD))
            req_cnt <= req_cnt + 1'b1;
         win_q <= (col_s >= 0) && (col_s < C_W'(CUR_W)) && cur_on;
      end
   end

   // R2: requests step by one word within a line
   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && $past(fetch_req) && !$past(line_start))
         |-> fetch_addr == $past(fetch_addr) + ADDR_W'(GRP_W / 8));

   // R2: never more requests than words in a line
   assert_req_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_cnt <= RC_W'(NWORD));

   // R11: output valid tracks input valid one cycle later
   assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> out_valid);

   assert_valid_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !out_valid);

   // R3: pixels not overridden pass unchanged
   assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> (out_ovr || out_rgb == $past(pix_rgb)));

   // R11: no override while cursor is off
   assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_on |=> !out_ovr);

   // R9: overrides only inside the cursor's screen window
   assert_ovr_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovr |-> (win_q && out_valid));

endmodule

bind hwcur_overlay hwcur_overlay_chk #(
   .CUR_W(CUR_W), .GRP_W(GRP_W), .ADDR_W(ADDR_W), .X_W(X_W), .PIX_W(PIX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .line_start(line_start),
   .fetch_req(fetch_req), .fetch_addr(fetch_addr),
   .cur_on(cur_on), .cur_x(cur_x),
   .pix_valid(pix_valid), .pix_x(pix_x), .pix_rgb(pix_rgb),
   .out_valid(out_valid), .out_rgb(out_rgb), .out_ovr(out_ovr)
);

// File: tb/tb_hwcur_overlay.sv
module tb_hwcur_overlay;
   localparam int CLK_PERIOD = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_start = 1'b0, line_start = 1'b0;
   logic [23:0]       base_addr = '0;
   logic [2:0]        depth = '0;
   logic              alt_mode = 1'b0;
   logic [31:0]       fg_col = '0, bg_col = '0;
   logic              cur_on = 1'b0;
   logic signed [12:0] cur_x = '0;
   logic              fetch_req;
   logic [23:0]       fetch_addr;
   logic [15:0]       fetch_rdata = '0;
   logic [7:0]        pal_idx;
   logic [31:0]       pal_rgb = '0;
   logic              pix_valid = 1'b0;
   logic [11:0]       pix_x = '0;
   logic [31:0]       pix_rgb = '0;
   logic              out_valid;
   logic [31:0]       out_rgb;
   logic              out_ovr;

   always #(CLK_PERIOD/2) clk = ~clk;

   hwcur_overlay dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
      .base_addr(base_addr), .depth(depth), .alt_mode(alt_mode),
      .fg_col(fg_col), .bg_col(bg_col), .cur_on(cur_on), .cur_x(cur_x),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_rdata(fetch_rdata),
      .pal_idx(pal_idx), .pal_rgb(pal_rgb),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_rgb(pix_rgb),
      .out_valid(out_valid), .out_rgb(out_rgb), .out_ovr(out_ovr)
   );

   // memory and palette models, one-cycle latency
   logic [15:0] mem [64];

   function automatic logic [31:0] pal_f(input logic [7:0] i);
      return {8'h00, i, i ^ 8'hff, i ^ 8'h3c};
   endfunction

   always @(posedge clk) begin
      if (fetch_req) fetch_rdata <= mem[fetch_addr[6:1]];
      pal_rgb <= pal_f(pal_idx);
   end

   // request recorder
   logic [23:0] req_a [16];
   int          req_n = 0;
   always @(posedge clk) begin
      if (line_start) req_n <= 0;
      else if (fetch_req && req_n < 16) begin
         req_a[req_n] <= fetch_addr;
         req_n <= req_n + 1;
      end
   end

   int  checks = 0, failures = 0;
   bit  finished = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // bench model state
   logic [23:0] exp_line = '0, line_now = '0;
   logic [31:0] m_fg, m_bg;
   bit          m_alt = 0, model_on = 0;

   function automatic logic [7:0] x5(input logic [4:0] v);
      return (8'(v) << 3) | (8'(v) >> 2);
   endfunction
   function automatic logic [7:0] x6(input logic [5:0] v);
      return (8'(v) << 2) | (8'(v) >> 4);
   endfunction

   function automatic logic [31:0] bconv(input logic [31:0] raw, input logic [2:0] dep, input bit alt);
      if (alt) return raw;
      case (dep)
         3'd0: return pal_f(raw[7:0]);
         3'd1: return {8'h00, x5(raw[14:10]), x5(raw[9:5]), x5(raw[4:0])};
         3'd2: return {8'h00, x5(raw[15:11]), x6(raw[10:5]), x5(raw[4:0])};
         default: return raw;
      endcase
   endfunction

   function automatic logic [31:0] model(input int x, input logic [31:0] under, output bit ovr);
      int c, g, j;
      bit m, d;
      logic [5:0] wi;
      ovr = 0;
      c = x - int'(cur_x);
      if (!(model_on && cur_on && c >= 0 && c < 64)) return under;
      g = c / 16;
      j = c % 16;
      wi = 6'((line_now >> 1) + 24'(2*g));
      m = mem[wi][15-j] ^ m_alt;
      d = mem[6'(wi + 6'd1)][15-j];
      if (!m) return under;
      ovr = 1;
      return d ? m_fg : m_bg;
   endfunction

   task automatic fill(input logic [23:0] a, input int seed);
      for (int k = 0; k < 8; k++)
         mem[6'((a >> 1) + 24'(k))] = 16'((seed * 40503 + k * 4951) ^ 16'hA5C3);
   endtask

   task automatic finish_prep();
      bit ok;
      repeat (12) @(negedge clk);
      ok = (req_n == 8);
      for (int k = 0; k < 8; k++)
         if (req_a[k] != line_now + 24'(2*k)) ok = 0;
      check(ok, "R2 request sequence", 32'(req_a[0]), 32'(line_now));
      model_on = 1;
   endtask

   task automatic prep_line(input bit newf, input logic [23:0] base, input int seed, input bit wait_done);
      @(negedge clk);
      base_addr   = base;
      frame_start = newf;
      line_start  = 1'b1;
      if (newf) exp_line = base;
      line_now = exp_line;
      exp_line = exp_line + 24'd16;
      fill(line_now, seed);
      m_fg = bconv(fg_col, depth, alt_mode);
      m_bg = bconv(bg_col, depth, alt_mode);
      m_alt = alt_mode;
      model_on = 0;
      @(negedge clk);
      frame_start = 1'b0;
      line_start  = 1'b0;
      if (wait_done) finish_prep();
   endtask

   task automatic scan(input int x0, input int n, input string tag);
      logic [31:0] e;
      bit eo;
      for (int i = 0; i < n; i++) begin
         pix_valid = 1'b1;
         pix_x     = 12'(x0 + i);
         pix_rgb   = 32'hC000_0000 | (32'(x0 + i) * 32'h0001_0101);
         e = model(x0 + i, pix_rgb, eo);
         @(negedge clk);
         check(out_valid && out_rgb == e && out_ovr == eo, tag, out_rgb, e);
      end
      pix_valid = 1'b0;
      @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check(!out_valid, "R1 out_valid", 32'(out_valid), 0);
      check(!out_ovr,   "R1 out_ovr",   32'(out_ovr),   0);
      check(!fetch_req, "R1 fetch_req", 32'(fetch_req), 0);
   endtask

   task automatic t_raw32();
      depth = 3'd4; alt_mode = 0; cur_on = 1; cur_x = 13'sd10;
      fg_col = 32'h5A3C_E7B9; bg_col = 32'h81F0_1D46;
      prep_line(1, 24'h000100, 1, 1);
      scan(0, 84, "R3 R7 32bpp");
   endtask

   task automatic t_pal8();
      depth = 3'd0;
      prep_line(0, 24'h0, 2, 1);   // second line: base + 16
      scan(0, 84, "R4 8bpp palette");
   endtask

   task automatic t_exp15();
      depth = 3'd1; fg_col = 32'h0000_7C1F; bg_col = 32'h0000_2A95;
      prep_line(1, 24'h000040, 3, 1);
      scan(5, 70, "R5 15bpp");
   endtask

   task automatic t_exp16();
      depth = 3'd2; fg_col = 32'h0000_F81F; bg_col = 32'h0000_07E5;
      prep_line(0, 24'h0, 4, 1);
      scan(5, 70, "R6 16bpp");
   endtask

   task automatic t_raw24();
      depth = 3'd3; fg_col = 32'h00AB_CDEF; bg_col = 32'h0012_3456;
      prep_line(0, 24'h0, 5, 1);
      scan(5, 70, "R7 24bpp");
   endtask

   task automatic t_alt();
      alt_mode = 1; depth = 3'd0; fg_col = 32'h1234_5611; bg_col = 32'h0BAD_F00D;
      prep_line(1, 24'h000080, 6, 1);
      scan(5, 70, "R8 alt 8bpp");
      depth = 3'd1;
      prep_line(0, 24'h0, 7, 1);
      scan(5, 70, "R8 alt 15bpp");
      alt_mode = 0;
   endtask

   task automatic t_negx();
      depth = 3'd4; cur_x = -13'sd20; fg_col = 32'h00FF_0000; bg_col = 32'h0000_FF00;
      prep_line(0, 24'h0, 8, 1);
      scan(0, 50, "R9 negative cur_x");
   endtask

   task automatic t_stable();
      depth = 3'd2; cur_x = 13'sd3; fg_col = 32'h0000_A5A5; bg_col = 32'h0000_5A5A;
      prep_line(0, 24'h0, 9, 1);
      fg_col = 32'hFFFF_FFFF; bg_col = 32'h0; depth = 3'd0; alt_mode = 1;
      scan(0, 70, "R10 latched controls");
      alt_mode = 0;
   endtask

   task automatic t_off();
      depth = 3'd4; cur_x = 13'sd0; fg_col = 32'h0F0F_0F0F; bg_col = 32'hF0F0_F0F0;
      prep_line(0, 24'h0, 10, 0);
      scan(0, 5, "R11 during preparation");
      finish_prep();
      cur_on = 0;
      scan(0, 40, "R11 cursor off");
      cur_on = 1;
      scan(0, 20, "R11 cursor on again");
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_raw32();
      t_pal8();
      t_exp15();
      t_exp16();
      t_raw24();
      t_alt();
      t_negx();
      t_stable();
      t_off();
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      report();
   end

endmodule